// File: doc/BRIEF.md
# Link Frame Slot Scheduler with Periodic Sync

This block divides a serial memory link into repeating periods of frames and decides, frame by frame, which traffic source owns each of the three slots (A, B, C) of the frame. Every frame is marked by a one-cycle `frame_tick`. On that tick the block reads the pending request levels and latches the owner code for each slot. These codes are held until the next tick, and the downstream framer uses them to build the frame.

Each period has fixed roles. The last frame carries the sync packet and takes all three slots. The frame before it is reserved for configuration: a configuration read goes in slot A and a configuration write goes in slots B and C. Every earlier frame carries normal DRAM traffic: a command goes in slot A and write data goes in slots B and C. A slot with no request gets the idle code. The period length is programmable and can be shorter than the nominal 42 frames, so that sync can be sent more often when clock ratios require it. A new length takes effect at a period boundary, so a period is never cut short partway through.

Top module: `link_frame_sched`

## Requirements
- R1: After reset all three slot selects are idle, `sync_strobe` is low and the period length is MAX_PERIOD (42). With no length change, the first sync frame is therefore the 42nd `frame_tick` after reset.
- R2: The slot owner encoding is 2 bits: 0 idle, 1 DRAM traffic, 2 configuration, 3 sync. The selects take their new value in the cycle after a `frame_tick`.
- R3: In a normal-traffic frame, slot A is DRAM (1) if `dram_cmd_req` is high and idle otherwise. Slots B and C are DRAM (1) if `wr_data_req` is high and idle otherwise.
- R4: In the configuration frame (the second-to-last frame of the period), slot A is configuration (2) if `cfg_rd_req` is high. Slots B and C are configuration (2) if `cfg_wr_req` is high. Both may be granted in the same frame. DRAM requests have no effect on this frame.
- R5: Configuration requests have no effect on normal-traffic frames. A request that is pending outside the configuration frame is served only at the next configuration frame.
- R6: In the sync frame (the last frame of the period), all three slots carry sync (3) whatever the requests are. `sync_strobe` is high for exactly the one cycle after that tick.
- R7: The value of `period_len` is clamped to the range 3 to MAX_PERIOD. It is sampled on the sync-frame tick and sets the length of the following period.
- R8: Slots B and C always carry the same owner code.
- R9: Without a `frame_tick`, the slot selects do not change and `sync_strobe` stays low, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle pulse that starts a frame |
| period_len | input | CNT_W (6) | Requested period length in frames |
| dram_cmd_req | input | 1 | DRAM command pending |
| wr_data_req | input | 1 | DRAM write data pending |
| cfg_rd_req | input | 1 | Configuration read pending |
| cfg_wr_req | input | 1 | Configuration write pending |
| slot_a_sel | output | 2 | Owner code of slot A |
| slot_b_sel | output | 2 | Owner code of slot B |
| slot_c_sel | output | 2 | Owner code of slot C |
| sync_strobe | output | 1 | Pulse marking the sync frame |

## Verification
Two pairs of events can meet in one cycle. The first is a configuration read and a configuration write, with DRAM requests also pending, at the same configuration-frame tick. The bench holds every request high at that frame and expects configuration in A and in B and C, with no DRAM code anywhere. The second is a change of `period_len` that lands on the sync-frame tick. The bench changes the length within the period before the sync tick, and also to values outside the legal range. It then counts the ticks up to the next sync pulse and compares that count with the clamped length the requirements give.

// File: rtl/link_sched_pkg.sv
package link_sched_pkg;

    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_DRAM = 2'd1,
        OWN_CFG  = 2'd2,
        OWN_SYNC = 2'd3
    } owner_e;

    typedef enum logic [1:0] {
        ROLE_NORMAL = 2'd0,
        ROLE_CFG    = 2'd1,
        ROLE_SYNC   = 2'd2
    } role_e;

    // shortest period that still holds one traffic, one config and one sync frame
    localparam int unsigned MIN_PERIOD = 3;

endpackage

// File: rtl/lfs_frame_counter.sv
module lfs_frame_counter
    import link_sched_pkg::*;
#(
    parameter int unsigned MAX_PERIOD = 42,
    parameter int unsigned CNT_W      = $clog2(MAX_PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic [CNT_W-1:0] period_len,
    output role_e            role
);

    localparam logic [CNT_W-1:0] LEN_MIN = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(MAX_PERIOD);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;   // number of the frame issued on the next tick
        logic [CNT_W-1:0] plen;  // length of the running period
    } ctr_t;

    ctr_t             ctr_d, ctr_q;
    logic [CNT_W-1:0] plen_new;

    always_comb begin
        if (period_len < LEN_MIN)      plen_new = LEN_MIN;
        else if (period_len > LEN_MAX) plen_new = LEN_MAX;
        else                           plen_new = period_len;

        if (ctr_q.cnt >= ctr_q.plen)             role = ROLE_SYNC;
        else if (ctr_q.cnt == ctr_q.plen - ONE)  role = ROLE_CFG;
        else                                     role = ROLE_NORMAL;

        ctr_d = ctr_q;
        if (frame_tick) begin
            if (role == ROLE_SYNC) begin
                ctr_d.cnt  = ONE;
                ctr_d.plen = plen_new;
            end else begin
                ctr_d.cnt  = ctr_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q.cnt  <= ONE;
            ctr_q.plen <= LEN_MAX;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assert_cnt_in_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.cnt >= ONE) && (ctr_q.cnt <= ctr_q.plen));

    assert_plen_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.plen >= LEN_MIN) && (ctr_q.plen <= LEN_MAX));

    assert_still_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(ctr_q));

    assert_restart_after_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && role == ROLE_SYNC) |=> (ctr_q.cnt == ONE));

endmodule

// File: rtl/lfs_slot_mux.sv
module lfs_slot_mux
    import link_sched_pkg::*;
(
    input  role_e  role,
    input  logic   dram_cmd_req,
    input  logic   wr_data_req,
    input  logic   cfg_rd_req,
    input  logic   cfg_wr_req,
    output owner_e own_a,
    output owner_e own_bc
);

    always_comb begin
        unique case (role)
            ROLE_SYNC: begin
                own_a  = OWN_SYNC;
                own_bc = OWN_SYNC;
            end
            ROLE_CFG: begin
                own_a  = cfg_rd_req ? OWN_CFG : OWN_IDLE;
                own_bc = cfg_wr_req ? OWN_CFG : OWN_IDLE;
            end
            default: begin
                own_a  = dram_cmd_req ? OWN_DRAM : OWN_IDLE;
                own_bc = wr_data_req  ? OWN_DRAM : OWN_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/link_frame_sched.sv
module link_frame_sched
    import link_sched_pkg::*;
#(
    parameter int unsigned MAX_PERIOD = 42,
    parameter int unsigned CNT_W      = $clog2(MAX_PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic [CNT_W-1:0] period_len,
    input  logic             dram_cmd_req,
    input  logic             wr_data_req,
    input  logic             cfg_rd_req,
    input  logic             cfg_wr_req,
    output logic [1:0]       slot_a_sel,
    output logic [1:0]       slot_b_sel,
    output logic [1:0]       slot_c_sel,
    output logic             sync_strobe
);

    typedef struct packed {
        owner_e a;
        owner_e b;
        owner_e c;
        logic   sync;
    } out_t;

    role_e  role;
    owner_e mux_a, mux_bc;
    out_t   out_d, out_q;

    lfs_frame_counter #(
        .MAX_PERIOD (MAX_PERIOD),
        .CNT_W      (CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .period_len (period_len),
        .role       (role)
    );

    lfs_slot_mux u_mux (
        .role         (role),
        .dram_cmd_req (dram_cmd_req),
        .wr_data_req  (wr_data_req),
        .cfg_rd_req   (cfg_rd_req),
        .cfg_wr_req   (cfg_wr_req),
        .own_a        (mux_a),
        .own_bc       (mux_bc)
    );

    always_comb begin
        out_d      = out_q;
        out_d.sync = 1'b0;
        if (frame_tick) begin
            out_d.a    = mux_a;
            out_d.b    = mux_bc;
            out_d.c    = mux_bc;
            out_d.sync = (role == ROLE_SYNC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.a    <= OWN_IDLE;
            out_q.b    <= OWN_IDLE;
            out_q.c    <= OWN_IDLE;
            out_q.sync <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign slot_a_sel  = out_q.a;
    assign slot_b_sel  = out_q.b;
    assign slot_c_sel  = out_q.c;
    assign sync_strobe = out_q.sync;

    assert_sync_owns_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_strobe |-> (slot_a_sel == 2'd3 && slot_b_sel == 2'd3 && slot_c_sel == 2'd3));

    assert_sync_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_strobe |=> !sync_strobe);

    assert_bc_paired_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_b_sel == slot_c_sel);

    assert_cfg_unmixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_a_sel == 2'd2 || slot_b_sel == 2'd2)
            |-> (slot_a_sel != 2'd1 && slot_b_sel != 2'd1 && slot_a_sel != 2'd3));

    assert_selects_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable({slot_a_sel, slot_b_sel, slot_c_sel}) && !sync_strobe));

endmodule

// File: tb/link_frame_sched_tb.sv
module link_frame_sched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 42;
    localparam int CW         = $clog2(MAXP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_tick = 1'b0;
    logic [CW-1:0] period_len = CW'(MAXP);
    logic          dram_cmd_req = 1'b0, wr_data_req = 1'b0;
    logic          cfg_rd_req = 1'b0, cfg_wr_req = 1'b0;
    logic [1:0]    slot_a_sel, slot_b_sel, slot_c_sel;
    logic          sync_strobe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // bench model of the period position
    int m_cnt  = 1;
    int m_plen = MAXP;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_frame_sched #(.MAX_PERIOD(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .period_len(period_len),
        .dram_cmd_req(dram_cmd_req), .wr_data_req(wr_data_req),
        .cfg_rd_req(cfg_rd_req), .cfg_wr_req(cfg_wr_req),
        .slot_a_sel(slot_a_sel), .slot_b_sel(slot_b_sel), .slot_c_sel(slot_c_sel),
        .sync_strobe(sync_strobe)
    );

    function automatic int clamp_len(int v);
        if (v < 3) return 3;
        if (v > MAXP) return MAXP;
        return v;
    endfunction

    task automatic check(string req, logic [6:0] act, logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got a/b/c/sync=%b expected %b", req, act, exp);
        end
    endtask

    // one frame: drive requests with a tick, compare the latched selects
    task automatic run_frame(input logic dc, input logic wd, input logic cr,
                             input logic cw, output logic got_sync);
        logic [1:0] ea, ebc;
        logic       es;
        string      tag;
        if (m_cnt == m_plen) begin
            ea = 2'd3; ebc = 2'd3; es = 1'b1; tag = "R6 sync frame";
        end else if (m_cnt == m_plen - 1) begin
            ea = cr ? 2'd2 : 2'd0; ebc = cw ? 2'd2 : 2'd0; es = 1'b0; tag = "R4 config frame";
        end else begin
            ea = dc ? 2'd1 : 2'd0; ebc = wd ? 2'd1 : 2'd0; es = 1'b0; tag = "R3/R5 traffic frame";
        end
        @(negedge clk);
        dram_cmd_req = dc; wr_data_req = wd; cfg_rd_req = cr; cfg_wr_req = cw;
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        check(tag, {slot_a_sel, slot_b_sel, slot_c_sel, sync_strobe}, {ea, ebc, ebc, es});
        got_sync = sync_strobe;
        if (m_cnt == m_plen) begin
            m_cnt  = 1;
            m_plen = clamp_len(int'(period_len));
        end else begin
            m_cnt++;
        end
    endtask

    // run frames with varied requests until sync; compare period length
    task automatic run_period(int exp_len, string req);
        logic s = 1'b0;
        int   n = 0;
        for (int i = 1; i <= 64 && !s; i++) begin
            run_frame(i % 3 != 1, i % 4 < 2, i % 2 == 0, i % 3 != 0, s);
            n = i;
        end
        n_checks++;
        if (n != exp_len) begin
            n_errors++;
            $display("FAIL %s: period length %0d expected %0d", req, n, exp_len);
        end
    endtask

    task automatic t_reset();
        check("R1 reset state", {slot_a_sel, slot_b_sel, slot_c_sel, sync_strobe}, 7'b0);
    endtask

    // first period: config requests pending all along, all requests at config frame
    task automatic t_first_period();
        logic s;
        int   syncs = 0;
        period_len = CW'(40);  // sampled at this period's sync tick
        for (int i = 1; i <= MAXP - 2; i++) begin
            run_frame(i % 3 != 0, i % 2 == 1, 1'b1, 1'b1, s);  // R5 cfg ignored here
            if (s) syncs++;
        end
        run_frame(1'b1, 1'b1, 1'b1, 1'b1, s);  // R4 read+write together, DRAM ignored
        if (s) syncs++;
        run_frame(1'b1, 1'b1, 1'b1, 1'b1, s);  // R6 requests ignored
        n_checks++;
        if (!(s && syncs == 0)) begin
            n_errors++;
            $display("FAIL R1: first sync at tick %0d, early syncs=%0d expected tick 42 and 0",
                     s ? MAXP : 0, syncs);
        end
    endtask

    task automatic t_hold();
        logic       s;
        logic [6:0] snap;
        run_frame(1'b1, 1'b0, 1'b0, 1'b0, s);
        snap = {slot_a_sel, slot_b_sel, slot_c_sel, sync_strobe};
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            dram_cmd_req = ~dram_cmd_req; wr_data_req = ~wr_data_req;
            cfg_rd_req = ~cfg_rd_req; cfg_wr_req = ~cfg_wr_req;
        end
        @(negedge clk);
        check("R9 no tick, no change", {slot_a_sel, slot_b_sel, slot_c_sel, sync_strobe}, snap);
        n_checks++;
        if (slot_b_sel !== slot_c_sel) begin
            n_errors++;
            $display("FAIL R8: b=%0d c=%0d expected equal", slot_b_sel, slot_c_sel);
        end
    endtask

    task automatic t_sync_pulse_width();
        @(negedge clk);
        n_checks++;
        if (sync_strobe !== 1'b0) begin
            n_errors++;
            $display("FAIL R6: sync_strobe=%b one cycle after pulse expected 0", sync_strobe);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_period();
        t_sync_pulse_width();
        t_hold();
        period_len = CW'(1);           // R7 below minimum, lands at this sync
        run_period(39, "R7 programmed length 40");  // one frame already used by t_hold
        t_sync_pulse_width();
        period_len = CW'(63);          // R7 above maximum
        run_period(3, "R7 length clamped to 3");
        period_len = CW'(MAXP);
        run_period(MAXP, "R7 length clamped to 42");
        run_period(MAXP, "R2 steady period");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule